// File: doc/BRIEF.md
# Two-Level Pending Interrupt Controller

This block gathers up to 32 interrupt request lines and decides what the processor sees. It records every incoming request in a latched request register, whether or not the source is masked. From the sources that are unmasked and routed to the normal interrupt path, it picks one winner by fixed priority. That winner is held as a single one-hot bit in a second register, the granted register. A per-source route register sends a source to the fast interrupt output instead. Those sources skip arbitration entirely.

Software reads and writes the registers through a plain single-cycle register port. A write is one cycle with `reg_wr` high; a read returns combinational data for the address on `reg_addr`. The port has no handshake and never stalls, so it has no back-pressure rules. No data stream flows through the block. Software retires an interrupt in two steps: it writes a 1 to the source's bit in the latched register, then writes a 1 to the same bit in the granted register. Once the granted register is empty, the next winner is chosen on the following clock.

Top module: `intc_dual_pend`

## Requirements
- R1: Two registers hold pending state, the latched register (address 0) and the granted register (address 3). A request bit high at a rising edge sets the matching bit of the latched register. This happens whatever the mask and route bits are.
- R2: The mask register (address 1) is read/write. A 1 in bit i blocks source i. A blocked source still latches, but it never becomes a winner and never drives `fiq_o`.
- R3: The granted register holds at most one set bit. A new winner is loaded only on an edge at which the granted register is all zeros. The winner is the lowest-numbered source whose latched bit is 1, mask bit is 0 and route bit is 0, as registered before that edge.
- R4: Both pending registers are write-one-to-clear. A 1 in the write data clears that bit, and a 0 leaves it unchanged.
- R5: If a request is high in the same cycle that software clears its latched bit, the request wins and the bit stays 1.
- R6: The route register (address 2) is read/write. Bit value 1 sends the source to the fast path, and 0 sends it to the normal path. Fast-path sources never enter the granted register. `fiq_o` is the OR of all latched bits that are unmasked and on the fast path.
- R7: `irq_o` is 1 exactly when the granted register is nonzero. The index register (address 4, read-only) returns the binary number of the winner, or 0 when there is none.
- R8: After reset, both pending registers are 0, every mask bit is 1, and every route bit is 0. `irq_o` and `fiq_o` are 0 after reset.
- R9: Reading an address above 4 returns 0, and writing it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_SRC | Request lines, level or one-cycle pulse |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | NUM_SRC | Write data |
| reg_rdata | output | NUM_SRC | Read data for reg_addr (combinational) |
| irq_o | output | 1 | Normal interrupt, granted register nonzero |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
Two functions can meet on the same edge: a raw request setting a latched bit, and a software write-one-to-clear of that same bit. The bench holds a request line high while it writes a clear to that bit in the same cycle. After the edge it reads the latched register back through the port and expects the bit to still be 1. It then drops the request and clears the bit again, and expects the bit to read 0. This shows that the earlier result came from request precedence and not from a dead clear path.

A second overlap happens when the granted register empties on the same edge that a higher-priority source latches. The bench checks that the winner is taken only one cycle after the granted register reads zero.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_LATCH = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd1;
  localparam logic [ADDR_W-1:0] A_ROUTE = 3'd2;
  localparam logic [ADDR_W-1:0] A_GRANT = 3'd3;
  localparam logic [ADDR_W-1:0] A_INDEX = 3'd4;
endpackage

// File: rtl/intc_req_latch.sv
module intc_req_latch #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] latch_q
);
  // Request has precedence over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= (latch_q & ~clr_i) | req_i;
  end

  // R1 R5
  req_sets_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i != '0) |=> ((latch_q & $past(req_i)) == $past(req_i)));

  // R4
  untouched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == '0 && req_i == '0) |=> $stable(latch_q));
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0] eligible_i,
  output logic [NUM_SRC-1:0] grant_o
);
  logic [NUM_SRC-1:0] lower_hit;

  // lower_hit[i] is set when some source below i is eligible
  assign lower_hit[0] = 1'b0;
  for (genvar i = 1; i < NUM_SRC; i++) begin : g_chain
    assign lower_hit[i] = lower_hit[i-1] | eligible_i[i-1];
  end

  assign grant_o = eligible_i & ~lower_hit;

  always_comb begin
    if (!$isunknown(eligible_i)) begin
      // R3
      grant_onehot_chk: assert ($onehot0(grant_o) && ((grant_o & ~eligible_i) == '0));
    end
  end
endmodule

// File: rtl/intc_onehot_enc.sv
module intc_onehot_enc #(
  parameter int NUM_SRC = 32,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] onehot_i,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (onehot_i[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/intc_dual_pend.sv
module intc_dual_pend #(
  parameter int NUM_SRC = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            req_i,
  input  logic [intc_pkg::ADDR_W-1:0]   reg_addr,
  input  logic                          reg_wr,
  input  logic [NUM_SRC-1:0]            reg_wdata,
  output logic [NUM_SRC-1:0]            reg_rdata,
  output logic                          irq_o,
  output logic                          fiq_o
);
  import intc_pkg::*;
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] latch_q, mask_q, route_q, grant_q;
  logic [NUM_SRC-1:0] clr_latch, clr_grant, eligible, pick;
  logic [IDX_W-1:0]   win_idx;
  logic               wr_mask, wr_route;

  assign clr_latch = (reg_wr && reg_addr == A_LATCH) ? reg_wdata : '0;
  assign clr_grant = (reg_wr && reg_addr == A_GRANT) ? reg_wdata : '0;
  assign wr_mask   = reg_wr && reg_addr == A_MASK;
  assign wr_route  = reg_wr && reg_addr == A_ROUTE;

  intc_req_latch #(.NUM_SRC(NUM_SRC)) u_latch (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(clr_latch), .latch_q(latch_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      route_q <= '0;
    end else begin
      if (wr_mask)  mask_q  <= reg_wdata;
      if (wr_route) route_q <= reg_wdata;
    end
  end

  // Normal-path candidates: latched, unmasked, not routed to fast path
  assign eligible = latch_q & ~mask_q & ~route_q;

  intc_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .eligible_i(eligible), .grant_o(pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              grant_q <= '0;
    else if (grant_q != '0)  grant_q <= grant_q & ~clr_grant;
    else                     grant_q <= pick;
  end

  intc_onehot_enc #(.NUM_SRC(NUM_SRC)) u_enc (
    .onehot_i(grant_q), .idx_o(win_idx)
  );

  assign irq_o = |grant_q;
  assign fiq_o = |(latch_q & ~mask_q & route_q);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_LATCH: reg_rdata = latch_q;
      A_MASK:  reg_rdata = mask_q;
      A_ROUTE: reg_rdata = route_q;
      A_GRANT: reg_rdata = grant_q;
      A_INDEX: reg_rdata[IDX_W-1:0] = win_idx;
      default: reg_rdata = '0;
    endcase
  end

  // R3
  grant_onehot_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));

  // R3
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q != '0 && clr_grant == '0) |=> $stable(grant_q));

  // R2
  grant_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q == '0) |=> ((grant_q & $past(mask_q)) == '0));

  // R6
  grant_not_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q == '0) |=> ((grant_q & $past(route_q)) == '0));

  // R7
  index_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q != '0) |-> grant_q[win_idx]);
endmodule

// File: tb/intc_dual_pend_test.sv
module intc_dual_pend_test;
  localparam int N = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_i = '0;
  logic [2:0]   reg_addr = '0;
  logic         reg_wr = 1'b0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic         irq_o, fiq_o;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  localparam int NV = 6;
  localparam logic [N-1:0] REQ_TAB [NV] = '{32'h0000_0001, 32'h8000_0000, 32'h0000_00F0,
                                             32'h0A00_0400, 32'hFFFF_FFFF, 32'h0003_0000};
  localparam int IDX_TAB [NV] = '{0, 31, 4, 10, 0, 16};

  always #10 clk = ~clk;

  intc_dual_pend #(.NUM_SRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, output logic [N-1:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(logic [N-1:0] r);
    req_i = r;
    tick();
    req_i = '0;
  endtask

  task automatic clear_all();
    wr(3'd0, '1);
    wr(3'd3, '1);
    tick();
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [N-1:0] v;
    #25 rst_n = 1'b1;
    tick();
    // R8 reset state
    rd(3'd0, v); chk("R8 latch reset", v, '0);
    rd(3'd3, v); chk("R8 grant reset", v, '0);
    rd(3'd1, v); chk("R8 mask reset", v, '1);
    rd(3'd2, v); chk("R8 route reset", v, '0);
    chk("R8 irq/fiq reset", {irq_o, fiq_o}, '0);

    // R1 R2 masked source latches but is not granted
    pulse(32'h8);
    tick(); tick();
    rd(3'd0, v); chk("R1 masked latch", v, 32'h8);
    rd(3'd3, v); chk("R2 masked no grant", v, '0);
    chk("R2 masked irq", irq_o, 0);
    wr(3'd1, ~32'h8);
    chk("R3 no grant at mask write edge", irq_o, 0);
    tick();
    chk("R3 grant after unmask", irq_o, 1);
    rd(3'd4, v); chk("R7 index 3", v, 3);
    clear_all();

    // R9 unmapped address
    wr(3'd6, 32'h1234);
    rd(3'd6, v); chk("R9 unmapped read", v, '0);

    // R3 R7 vector table: priority winner and index
    wr(3'd1, '0);
    for (int k = 0; k < NV; k++) begin
      pulse(REQ_TAB[k]);
      tick();
      rd(3'd0, v); chk("R1 table latch", v, REQ_TAB[k]);
      rd(3'd4, v); chk("R3 table winner", v, N'(IDX_TAB[k]));
      rd(3'd3, v); chk("R3 table grant onehot", v, N'(1) << IDX_TAB[k]);
      chk("R7 table irq", irq_o, 1);
      clear_all();
      chk("R4 table irq cleared", irq_o, 0);
    end

    // R3 winner held while higher priority arrives; R4 clear order
    pulse(32'h200);
    tick();
    pulse(32'h4);
    tick();
    rd(3'd4, v); chk("R3 winner held", v, 9);
    wr(3'd0, '0);
    rd(3'd0, v); chk("R4 zero write keeps latch", v, 32'h204);
    wr(3'd0, 32'h200);
    rd(3'd4, v); chk("R3 still 9 until grant cleared", v, 9);
    wr(3'd3, 32'h200);
    chk("R7 irq drops on empty grant", irq_o, 0);
    tick();
    rd(3'd4, v); chk("R3 next winner 2", v, 2);
    clear_all();

    // R6 fast path
    wr(3'd2, 32'h20);
    pulse(32'h20);
    chk("R6 fiq set", fiq_o, 1);
    tick();
    chk("R6 fast not granted", irq_o, 0);
    wr(3'd1, 32'h20);
    chk("R2 masked fiq low", fiq_o, 0);
    wr(3'd1, '0);
    chk("R6 fiq back", fiq_o, 1);
    wr(3'd0, 32'h20);
    chk("R6 fiq cleared", fiq_o, 0);
    wr(3'd2, '0);
    tick();
    chk("R6 no stale irq", irq_o, 0);

    // R5 request beats clear in the same cycle
    req_i = 32'h80;
    wr(3'd0, 32'h80);
    rd(3'd0, v); chk("R5 request wins", v & 32'h80, 32'h80);
    req_i = '0;
    wr(3'd0, 32'h80);
    rd(3'd0, v); chk("R5 later clear works", v & 32'h80, '0);
    clear_all();
    rd(3'd3, v); chk("R4 grant cleared", v, '0);

    done = 1'b1;
    report();
  end
endmodule